// File: doc/BRIEF.md
# Long-word asynchronous serial receiver

This block receives asynchronous serial frames that carry a 32-bit data word. A frame is 36 bit times long: one low start bit, 32 data bits sent least significant bit first, one parity bit and two high stop bits. The nominal rate is 9600 bit/s. The receiver first passes the line through a two-flop synchroniser. It then samples the line on a tick that runs at sixteen times the bit rate, with the tick divisor computed from the system clock frequency. A falling edge on the idle-high line starts a frame. The start bit is accepted only if the line is still low at its half-bit sample.

A frame this long can drift off the bit centre when the two ends' clocks disagree. To prevent this, the receiver re-centres its sixteen-phase bit counter on every level change it sees during the data and parity bits. Each later sample then lands half a bit after the most recent edge. After the second stop bit, the word goes into an 8-entry FIFO together with a parity-error flag and a framing-error flag. The host reads the FIFO through a valid/ready pair.

If a word completes while the FIFO is full, the word is lost and a sticky overrun flag rises. A dedicated clear input drops that flag. After a framing error, the receiver waits for the line to go high before it looks for a new start edge.

Top module: `lw_uart_rx`

## Requirements
- R1: After reset, out_valid is 0 and overrun is 0.
- R2: The bit time is 16 ticks and the tick period is CLK_HZ/(BAUD*16) clocks (at least 1). A frame is a low start bit, 32 data bits with bit 0 first, a parity bit and two stop bits. Its data bits appear on out_data with bit i of the word taken from the i-th data bit.
- R3: With ODD_PARITY=0, out_perr is 1 exactly when the number of 1s over the 32 data bits and the parity bit is odd.
- R4: With ODD_PARITY=1, out_perr is 1 exactly when the number of 1s over the 32 data bits and the parity bit is even.
- R5: A low pulse shorter than half a bit on the idle line is ignored: no word is produced, and the next proper frame is received correctly.
- R6: The sample phase is re-centred on every line transition during the data and parity bits. Frames whose bit period differs from nominal by 1/16 are therefore received correctly, provided no run of equal bits is longer than 2.
- R7: out_ferr is 1 when either stop-bit sample is low. The word is still stored, with its data intact.
- R8: After a framing error, the receiver takes no new frame while the line stays low. No extra word appears during a held-low line, and the first frame after the line returns high is received correctly.
- R9: The FIFO holds 8 entries in arrival order. out_valid is 1 while it is non-empty, and an entry is removed on a clock where out_valid and out_ready are both 1. out_data and the flags hold steady while out_valid is 1 and out_ready is 0.
- R10: A word that completes while the FIFO is full is dropped and sets overrun. overrun stays 1 until a cycle with ovr_clr high and no new drop; on a cycle with both, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Host takes the head word |
| out_data | output | 32 | Head word of the FIFO |
| out_perr | output | 1 | Parity error flag of the head word |
| out_ferr | output | 1 | Framing error flag of the head word |
| overrun | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
A single 1 is walked through all 32 data positions, and all-zero, all-one and mixed words are also sent. These show that the bit order is right and that each position maps to the right output bit, and the parity outcome changes with every word. Frames with a flipped parity bit, a low first stop bit, a low second stop bit, and both stop bits low followed by a held-low line separate the parity and framing checks from each other and from the wait-for-high behaviour. A glitch shorter than half a bit checks start validation. Alternating-pair words sent at bit periods 1/16 short and 1/16 long would fail without re-centring. Nine unread frames fill the FIFO and then overrun it, which checks ordering, the drop and the sticky flag with its clear.

// File: rtl/lw_rx_pkg.sv
package lw_rx_pkg;
  localparam int OVS     = 16;
  localparam int PH_W    = 4;
  localparam int PH_HALF = OVS / 2 - 1;
  localparam int PH_MID  = OVS / 2;
  localparam int PH_LAST = OVS - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_WAITHI
  } rx_state_t;

  // Clock cycles per oversample tick, never below one.
  function automatic int calc_div(input int clk_hz, input int baud);
    int d;
    d = clk_hz / (baud * OVS);
    return (d < 1) ? 1 : d;
  endfunction

  // Parity fails when the XOR of data and parity bit differs from the mode.
  function automatic logic parity_bad(input logic data_xor, input logic pbit,
                                      input logic odd_mode);
    return (data_xor ^ pbit) != odd_mode;
  endfunction
endpackage

// File: rtl/lw_rx_tick.sv
module lw_rx_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_s,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          meta;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      meta <= rx_async;
      rx_s <= meta;
    end
  end

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lw_rx_frame.sv
module lw_rx_frame
  import lw_rx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  output logic              word_done,
  output logic [DATA_W-1:0] word,
  output logic              perr,
  output logic              ferr,
  output logic              sample_evt,
  output logic              resync_evt
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t         state;
  logic [PH_W-1:0]   ph;
  logic              prev;
  logic [BW-1:0]     bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              stop1_bad;

  logic at_last, in_bits, edge_seen, stop_low;

  assign at_last   = (ph == PH_W'(PH_LAST));
  assign in_bits   = (state == ST_DATA) || (state == ST_PAR);
  assign edge_seen = (rx_s != prev);
  assign stop_low  = stop1_bad || !rx_s;

  assign sample_evt = tick && at_last &&
                      (in_bits || state == ST_STOP1 || state == ST_STOP2);
  assign resync_evt = tick && in_bits && !at_last && edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ph        <= '0;
      prev      <= 1'b1;
      bitcnt    <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      stop1_bad <= 1'b0;
    end else if (tick) begin
      prev <= rx_s;
      unique case (state)
        ST_IDLE: begin
          if (prev && !rx_s) begin
            state <= ST_START;
            ph    <= '0;
          end
        end
        ST_START: begin
          if (ph == PH_W'(PH_HALF)) begin
            ph     <= '0;
            bitcnt <= '0;
            state  <= rx_s ? ST_IDLE : ST_DATA;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_DATA, ST_PAR: begin
          if (at_last) begin
            ph <= '0;
            if (state == ST_DATA) begin
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              if (bitcnt == BW'(DATA_W - 1)) state <= ST_PAR;
              else bitcnt <= bitcnt + 1'b1;
            end else begin
              pbit  <= rx_s;
              state <= ST_STOP1;
            end
          end else if (edge_seen) begin
            ph <= PH_W'(PH_MID);
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_STOP1: begin
          if (at_last) begin
            ph        <= '0;
            stop1_bad <= !rx_s;
            state     <= ST_STOP2;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_STOP2: begin
          if (at_last) begin
            ph    <= '0;
            state <= stop_low ? ST_WAITHI : ST_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_WAITHI: begin
          if (rx_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_done <= 1'b0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      word_done <= tick && at_last && (state == ST_STOP2);
      if (tick && at_last && (state == ST_STOP2)) begin
        ferr <= stop_low;
        perr <= parity_bad(^shreg, pbit, ODD_PARITY);
      end
    end
  end

  assign word = shreg;
endmodule

// File: rtl/lw_rx_fifo.sv
module lw_rx_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic                       full,
  output logic                       empty,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= ptr_next(wr_ptr);
      if (pop && !empty) rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/lw_uart_rx.sv
module lw_uart_rx #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int BAUD       = 9600,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              ovr_clr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              overrun
);
  localparam int DIV   = lw_rx_pkg::calc_div(CLK_HZ, BAUD);
  localparam int ENT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic              rx_s, tick;
  logic              word_done, frm_perr, frm_ferr;
  logic [DATA_W-1:0] frm_word;
  logic              sample_evt, resync_evt;
  logic              fifo_full, fifo_empty;
  logic [ENT_W-1:0]  head;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_push, fifo_pop;

  lw_rx_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .rx_async(rx_line), .rx_s(rx_s), .tick(tick)
  );

  lw_rx_frame #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .word_done(word_done), .word(frm_word), .perr(frm_perr), .ferr(frm_ferr),
    .sample_evt(sample_evt), .resync_evt(resync_evt)
  );

  assign fifo_push = word_done && !fifo_full;
  assign fifo_pop  = out_valid && out_ready;

  lw_rx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push),
    .push_data({frm_perr, frm_ferr, frm_word}), .pop(fifo_pop),
    .full(fifo_full), .empty(fifo_empty), .rd_data(head), .count(fifo_count)
  );

  assign out_valid = !fifo_empty;
  assign out_data  = head[DATA_W-1:0];
  assign out_ferr  = head[DATA_W];
  assign out_perr  = head[DATA_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else if (word_done && fifo_full) overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end
endmodule

// File: rtl/lw_uart_rx_chk.sv
module lw_uart_rx_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [DATA_W-1:0]        out_data,
  input logic                     overrun,
  input logic                     ovr_clr,
  input logic                     word_done,
  input logic                     fifo_full,
  input logic [$clog2(DEPTH):0]   fifo_count,
  input logic                     resync_evt,
  input logic                     sample_evt
);
  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && fifo_full |=> overrun);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(word_done && fifo_full) |=> !overrun);

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_empty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> !out_valid);

  assert_resync_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |=> !sample_evt);
endmodule

bind lw_uart_rx lw_uart_rx_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/lw_uart_rx_tb.sv
`timescale 1ns/1ps
module lw_uart_rx_tb;
  localparam int BAUD   = 9600;
  localparam int CLK_HZ = 2 * 16 * BAUD;
  localparam int BITP   = 2 * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic ovr_clr = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_perr, out_ferr, overrun;
  logic [31:0] out_data;
  logic odd_valid, odd_perr, odd_ferr, odd_ovr;
  logic [31:0] odd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] odd_last_word;
  logic odd_last_perr;
  int odd_cnt = 0;

  always #4 clk = ~clk;

  lw_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .ovr_clr(ovr_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .overrun(overrun)
  );

  lw_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b1)) u_odd (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .ovr_clr(1'b0),
    .out_valid(odd_valid), .out_ready(1'b1), .out_data(odd_data),
    .out_perr(odd_perr), .out_ferr(odd_ferr), .overrun(odd_ovr)
  );

  always @(posedge clk) begin
    if (odd_valid) begin
      odd_last_word <= odd_data;
      odd_last_perr <= odd_perr;
      odd_cnt <= odd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int n);
    rx_line = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] w, input bit flip, input bit s1,
                            input bit s2, input int per, input int hold_low);
    drive(1'b0, per);
    for (int i = 0; i < 32; i++) drive(w[i], per);
    drive((^w) ^ flip, per);
    drive(s1, per);
    drive(s2, per);
    if (hold_low > 0) drive(1'b0, hold_low);
    drive(1'b1, 2 * BITP);
  endtask

  task automatic take(input string req, input logic [31:0] w, input bit pe, input bit fe);
    chk(req, {63'd0, out_valid}, 64'd1);
    chk(req, {32'd0, out_data}, {32'd0, w});
    chk(req, {62'd0, out_perr, out_ferr}, {62'd0, pe, fe});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic one_word(input string req, input logic [31:0] w, input bit flip,
                          input int per);
    send_frame(w, flip, 1'b1, 1'b1, per, 0);
    take(req, w, flip, 1'b0);
    chk(req, {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", {63'd0, out_valid}, 64'd0);
    chk("R1", {63'd0, overrun}, 64'd0);

    // R2 walking one over every data position, then assorted words
    for (int i = 0; i < 32; i++) one_word("R2", 32'd1 << i, 1'b0, BITP);
    one_word("R2", 32'h0000_0000, 1'b0, BITP);
    one_word("R2", 32'hFFFF_FFFF, 1'b0, BITP);
    one_word("R2", 32'h1234_5678, 1'b0, BITP);

    // R3 flipped parity bit on the even-mode receiver
    one_word("R3", 32'h0F0F_0F01, 1'b1, BITP);

    // R4 odd-mode receiver sees the same line
    send_frame(32'h0000_0001, 1'b0, 1'b1, 1'b1, BITP, 0);
    take("R4", 32'h0000_0001, 1'b0, 1'b0);
    chk("R4", {32'd0, odd_last_word}, 64'h1);
    chk("R4", {63'd0, odd_last_perr}, 64'd1);
    send_frame(32'h0000_0003, 1'b1, 1'b1, 1'b1, BITP, 0);
    take("R4", 32'h0000_0003, 1'b1, 1'b0);
    chk("R4", {63'd0, odd_last_perr}, 64'd0);

    // R5 short glitch, then a proper frame
    drive(1'b0, 6);
    drive(1'b1, 3 * BITP);
    chk("R5", {63'd0, out_valid}, 64'd0);
    one_word("R5", 32'hCAFE_F00D, 1'b0, BITP);

    // R6 bit period 1/16 short and 1/16 long
    one_word("R6", 32'h3333_3333, 1'b0, BITP - 2);
    one_word("R6", 32'hA5A5_A5A5, 1'b0, BITP + 2);
    one_word("R6", 32'hCCCC_CCCC, 1'b0, BITP + 2);
    one_word("R6", 32'h6666_6666, 1'b0, BITP - 2);

    // R7 either stop bit low
    send_frame(32'h8000_0001, 1'b0, 1'b0, 1'b1, BITP, 0);
    take("R7", 32'h8000_0001, 1'b0, 1'b1);
    send_frame(32'h0F00_00F0, 1'b0, 1'b1, 1'b0, BITP, 0);
    take("R7", 32'h0F00_00F0, 1'b0, 1'b1);

    // R8 both stops low and line held low, then a clean frame
    send_frame(32'h5A5A_0000, 1'b0, 1'b0, 1'b0, BITP, 5 * BITP);
    take("R8", 32'h5A5A_0000, 1'b0, 1'b1);
    chk("R8", {63'd0, out_valid}, 64'd0);
    one_word("R8", 32'h0123_4567, 1'b0, BITP);

    // R10 / R9 fill the FIFO and overrun it
    for (int k = 0; k < 9; k++) send_frame(32'h100 + k, 1'b0, 1'b1, 1'b1, BITP, 0);
    chk("R10", {63'd0, overrun}, 64'd1);
    for (int k = 0; k < 8; k++) take("R9", 32'h100 + k, 1'b0, 1'b0);
    chk("R9", {63'd0, out_valid}, 64'd0);
    chk("R10", {63'd0, overrun}, 64'd1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
    chk("R10", {63'd0, overrun}, 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule